// File: doc/BRIEF.md
# Two-Channel Sigma-Delta ADC Controller

This block is the digital half of a first-order, single-bit sigma-delta converter. Each channel watches one comparator-style input pin that sits behind an external RC integrator. The block drives a feedback pin back into that network. On every tick the feedback pin takes the inverse of the input, which keeps the integrator voltage near the threshold. The density of ones in the input stream then follows the analog level.

Each channel counts the ticks on which its input was high over a fixed window of 256 ticks. It then publishes that count as an 8-bit result and begins a new window. Two channels share one tick enable but keep their own counters and results. The input pins are asynchronous to the clock, so each one passes through a two-flop synchronizer before it is used.

Top module: `sdadc_ctrl`

## Requirements
- R1: On a clock edge where `tick_en` is high, each channel's `fb_out` bit takes the logical complement of that channel's synchronized input. Between ticks, `fb_out` holds its value.
- R2: Each `comp_in` bit passes through two flops before use. After a tick at edge k, `fb_out` reflects the value `comp_in` had just before edge k-2.
- R3: The ones count of a channel rises by one on each tick where its synchronized input is high. Edges without `tick_en` change no count, no result and no feedback bit.
- R4: A per-channel 8-bit window counter advances on every tick. On the tick where it wraps from 255 to 0, the result takes the number of high samples over exactly those 256 ticks, and the ones count restarts from zero.
- R5: When all 256 samples of a window are high, the result is 255 rather than wrapping to 0.
- R6: `result_valid` for a channel is high for exactly one clock, on the cycle after the wrapping tick. The result field does not change at any other time.
- R7: The channels are independent. Channel i's result sits in `result[i*8 +: 8]` and depends only on `comp_in[i]`.
- R8: While `rst_n` is low at a clock edge, all state clears: `fb_out` is 0, every result is 0, `result_valid` is 0 and counting starts afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Sample tick shared by all channels |
| comp_in | input | 2 | Asynchronous comparator input, one bit per channel |
| fb_out | output | 2 | Feedback drive to the RC integrator, one bit per channel |
| result | output | 16 | Packed 8-bit results, channel i at bits [i*8 +: 8] |
| result_valid | output | 2 | One-clock pulse per channel when its result updates |

## Verification
The embedded assertions check the following on every cycle:
- the feedback inversion against the previous synchronized sample;
- the two-edge synchronizer latency;
- that the ones count never runs ahead of the window counter;
- the single-cycle valid pulse, and that it follows a wrapping tick with the count already cleared;
- that the result holds steady between updates.

Only the bench scenarios can show that each result value is correct. They do this by comparing against a behavioural model under several inputs: constant high and low, alternating, sparse random, and irregular ticks. These scenarios also show saturation at 255, the independence of the two channels, and that inputs are ignored while ticks are absent.

// File: rtl/sdadc_pkg.sv
// Package: sdadc_pkg
// Shared defaults for the sigma-delta controller.
// Assumes: the result width also fixes the window length (2**width ticks).
package sdadc_pkg;
    localparam int unsigned SDADC_NUM_CH      = 2;
    localparam int unsigned SDADC_RES_W       = 8;
    localparam int unsigned SDADC_SYNC_STAGES = 2;

    // Saturating conversion from a one-bit-wider sum to the result width
    function automatic logic [SDADC_RES_W-1:0] sat_result(input logic [SDADC_RES_W:0] sum);
        return sum[SDADC_RES_W] ? {SDADC_RES_W{1'b1}} : sum[SDADC_RES_W-1:0];
    endfunction
endpackage

// File: rtl/sdadc_sync.sv
// Module: sdadc_sync
// Multi-flop synchronizer for one asynchronous input bit.
// Assumes: the input is a level that is stable for several clocks around
// changes; metastability is resolved within STAGES flops.
module sdadc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    // Shift the input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];

    generate
        if (STAGES == 2) begin : g_lat_chk
            // R2: the output equals the input seen two edges earlier
            a_r2_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2)) |-> (q == $past(d, 2)));
        end
    endgenerate
endmodule

// File: rtl/sdadc_channel.sv
// Module: sdadc_channel
// One conversion channel: feedback inversion, a ones count and a window
// counter, and a result register with a one-clock valid pulse.
// Assumes: sample is already synchronous to clk; tick marks the sample instants.
module sdadc_channel
    import sdadc_pkg::*;
#(
    parameter int unsigned RES_W = SDADC_RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sample,
    output logic             fb,
    output logic [RES_W-1:0] result,
    output logic             valid
);
    localparam logic [RES_W-1:0] LAST_TICK = {RES_W{1'b1}};

    logic [RES_W-1:0] win_cnt;
    logic [RES_W-1:0] ones_cnt;
    logic [RES_W:0]   final_sum;
    logic             wrap;

    assign wrap      = tick && (win_cnt == LAST_TICK);
    assign final_sum = {1'b0, ones_cnt} + {{RES_W{1'b0}}, sample};

    // Drive the feedback pin to the inverse of the sample on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)    fb <= 1'b0;
        else if (tick) fb <= ~sample;
    end

    // Advance the window counter on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)    win_cnt <= '0;
        else if (tick) win_cnt <= win_cnt + 1'b1;
    end

    // Count high samples; restart the count at the end of each window
    always_ff @(posedge clk) begin
        if (!rst_n)    ones_cnt <= '0;
        else if (wrap) ones_cnt <= '0;
        else if (tick) ones_cnt <= ones_cnt + {{(RES_W-1){1'b0}}, sample};
    end

    // Latch the saturated count at the window end and pulse valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= wrap;
            if (wrap) result <= sat_result(final_sum);
        end
    end

    // R1: after a tick, feedback is the inverse of the sample used at that tick
    a_r1_fb_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick)) |-> (fb == !$past(sample)));

    // R3: without a tick, feedback does not move
    a_r3_fb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick)) |-> $stable(fb));

    // R3: the ones count can never exceed the ticks seen in this window
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ones_cnt <= win_cnt);

    // R4: a valid pulse follows a last-tick edge and finds both counts cleared
    a_r4_window_end: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ($past(tick && (win_cnt == LAST_TICK)) && ones_cnt == '0 && win_cnt == '0));

    // R6: the valid pulse lasts one clock
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R6: the result only changes together with a valid pulse
    a_r6_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !valid) |-> $stable(result));
endmodule

// File: rtl/sdadc_ctrl.sv
// Module: sdadc_ctrl
// Top of the multi-channel sigma-delta controller: one synchronizer and one
// conversion channel per input, all sharing a common tick enable.
// Assumes: comp_in bits are asynchronous; tick_en is synchronous to clk.
module sdadc_ctrl
    import sdadc_pkg::*;
#(
    parameter int unsigned NUM_CH      = SDADC_NUM_CH,
    parameter int unsigned RES_W       = SDADC_RES_W,
    parameter int unsigned SYNC_STAGES = SDADC_SYNC_STAGES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_en,
    input  logic [NUM_CH-1:0]         comp_in,
    output logic [NUM_CH-1:0]         fb_out,
    output logic [NUM_CH*RES_W-1:0]   result,
    output logic [NUM_CH-1:0]         result_valid
);
    logic [NUM_CH-1:0] synced;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            sdadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (comp_in[ch]),
                .q     (synced[ch])
            );

            sdadc_channel #(.RES_W(RES_W)) u_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (tick_en),
                .sample (synced[ch]),
                .fb     (fb_out[ch]),
                .result (result[ch*RES_W +: RES_W]),
                .valid  (result_valid[ch])
            );
        end
    endgenerate

    // R8: outputs are cleared on the edge after a reset edge
    a_r8_reset_clear: assert property (@(posedge clk)
        $past(!rst_n) |-> (fb_out == '0 && result == '0 && result_valid == '0));
endmodule

// File: tb/sdadc_ctrl_tb.sv
// Bench: behavioural model of the two-channel controller, compared every clock.
module sdadc_ctrl_tb;
    localparam int NCH = 2;
    localparam int RW  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick_en = 1'b0;
    logic [NCH-1:0] comp_in = '0;
    logic [NCH-1:0] fb_out;
    logic [NCH*RW-1:0] result;
    logic [NCH-1:0] result_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit finished = 0;

    // model state
    int ms0 [NCH];
    int ms1 [NCH];
    int mfb [NCH];
    int mcnt[NCH];
    int macc[NCH];
    int mres[NCH];
    int mval[NCH];

    always #4 clk = ~clk;  // 125 MHz

    sdadc_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .comp_in      (comp_in),
        .fb_out       (fb_out),
        .result       (result),
        .result_valid (result_valid)
    );

    // Reference model, advanced on each rising edge
    always @(posedge clk) begin
        started <= 1'b1;
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                ms0[c] = 0; ms1[c] = 0; mfb[c] = 0; mcnt[c] = 0;
                macc[c] = 0; mres[c] = 0; mval[c] = 0;
            end else begin
                mval[c] = 0;
                if (tick_en) begin
                    mfb[c] = (ms1[c] != 0) ? 0 : 1;
                    macc[c] = macc[c] + ms1[c];
                    if (mcnt[c] == 255) begin
                        mres[c] = (macc[c] > 255) ? 255 : macc[c];
                        mval[c] = 1;
                        macc[c] = 0;
                    end
                    mcnt[c] = (mcnt[c] + 1) % 256;
                end
                ms1[c] = ms0[c];
                ms0[c] = comp_in[c] ? 1 : 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output with the model at each falling edge
    always @(negedge clk) begin
        if (started && !finished) begin
            for (int c = 0; c < NCH; c++) begin
                check(fb_out[c] == mfb[c][0], $sformatf("R1/R2 fb ch%0d", c), fb_out[c], mfb[c]);
                check(result[c*RW +: RW] == mres[c][RW-1:0], $sformatf("R4/R7 result ch%0d", c),
                      result[c*RW +: RW], mres[c]);
                check(result_valid[c] == mval[c][0], $sformatf("R6 valid ch%0d", c),
                      result_valid[c], mval[c]);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #(8 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [NCH-1:0] fb_hold;
        logic [NCH*RW-1:0] res_hold;
        int seed;
        seed = 17;
        void'($urandom(seed));

        // R8: reset state
        repeat (4) @(negedge clk);
        check(fb_out == '0 && result == '0 && result_valid == '0, "R8 reset state",
              {fb_out, result, result_valid}, 0);

        // R5, R7: ch0 constant high, ch1 constant low, tick on every clock
        rst_n = 1'b1;
        tick_en = 1'b1;
        comp_in = 2'b01;
        repeat (520) @(negedge clk);
        check(result[RW-1:0] == 8'd255, "R5 saturated full window", result[RW-1:0], 255);
        check(result[2*RW-1:RW] == 8'd0, "R7 other channel independent", result[2*RW-1:RW], 0);
        check(fb_out == 2'b10, "R1 fb inverse of constant inputs", fb_out, 2);

        // R4: alternating ch0, sparse random ch1
        for (int i = 0; i < 800; i++) begin
            comp_in[0] = ~comp_in[0];
            comp_in[1] = (($urandom % 4) == 0);
            @(negedge clk);
        end

        // R3: ticks withheld while inputs move; nothing may change
        tick_en = 1'b0;
        repeat (3) @(negedge clk);
        fb_hold = fb_out;
        res_hold = result;
        for (int i = 0; i < 300; i++) begin
            comp_in = NCH'($urandom);
            @(negedge clk);
        end
        check(fb_out == fb_hold, "R3 fb unchanged without tick", fb_out, fb_hold);
        check(result == res_hold, "R3 result unchanged without tick", result, res_hold);

        // R2, R4, R6: irregular ticks and random inputs
        for (int i = 0; i < 2500; i++) begin
            tick_en = $urandom % 2;
            comp_in = NCH'($urandom);
            @(negedge clk);
        end

        // R8: reset mid-run clears everything
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(fb_out == '0 && result == '0 && result_valid == '0, "R8 reset mid-run",
              {fb_out, result, result_valid}, 0);
        rst_n = 1'b1;
        tick_en = 1'b1;
        comp_in = 2'b10;
        repeat (600) @(negedge clk);
        check(result[2*RW-1:RW] == 8'd255, "R5 saturation on channel 1", result[2*RW-1:RW], 255);

        finish_run();
    end
endmodule